// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns software-generated interrupt requests into per-CPU pending state for a small interrupt distributor that serves up to eight CPUs. A CPU raises an interrupt by writing a 32-bit generate word. The word names an interrupt number, a target list and a filter mode. The block works out which CPUs receive the interrupt. For each of them it marks that interrupt pending and records the writing CPU as a source of it.

Every CPU has its own bank of source bitmaps, one 8-bit bitmap per interrupt number. An interrupt stays pending while any source bit remains set in its bitmap. Each CPU sees its own bank through two 16-byte windows on a simple register bus, one for setting bits and one for clearing them. Both windows read back the bitmaps. The bank that a window access touches is selected by the CPU-ID input. The flattened pending vector drives the distributor's arbitration logic further down the chain.

Top module: `sgi_dispatch`

## Requirements
- R1: Reset (rst_ni low) clears every source bitmap, so `pending_o` is all zero and window reads return zero afterwards.
- R2: A 32-bit write (`wide_i`=1) at offset 0x00 is a generate request. The interrupt number is in bits 3:0, the target list in bits 23:16 (bit 16+c selects CPU c) and the filter mode in bits 25:24. Filter mode 0 delivers to the listed CPUs.
- R3: Filter mode 1 delivers to every online CPU except the writer (`cpu_id_i`).
- R4: Filter mode 2 delivers only to the writer.
- R5: Filter mode 3 is reserved, and such a write changes no state.
- R6: For each CPU that receives the interrupt, bit `cpu_id_i` is ORed into that interrupt's bitmap in the receiver's bank, and the interrupt becomes pending there. Pending state changes only on bus writes.
- R7: CPUs with index at or above `num_cpus_i` never receive an interrupt from filter modes 0 or 1, whatever the target list says.
- R8: A write to the clear window (offsets 0x10–0x1F, byte 0x10+n holds interrupt n) clears the written 1-bits from the bitmap. Pending drops when the bitmap reaches zero.
- R9: A write to the set window (offsets 0x20–0x2F, byte 0x20+n holds interrupt n) ORs the written bits into the bitmap. Pending is set only if the result is nonzero.
- R10: Both windows read back the bitmaps in `rdata_o` one cycle after the read request, and the value is held until the next read. An 8-bit access (`wide_i`=0) covers the single interrupt at addr[3:0], with its data in bits 7:0. A 32-bit access covers four interrupts starting at 4×addr[3:2], with the lowest one in bits 7:0.
- R11: Window reads and writes act only on the bank of CPU `cpu_id_i`.
- R12: Reads of the generate register and of unmapped offsets (0x04–0x0F, 0x30–0x3F) return zero. Writes to unmapped offsets, and 8-bit writes to the generate register, change no state.
- R13: `pending_o` bit c×16+n is pending for interrupt n on CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| num_cpus_i | input | 4 | Number of online CPUs, 1 to 8, static |
| cpu_id_i | input | 3 | CPU issuing the current bus access |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| addr_i | input | 6 | Byte offset in the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pending_o | output | 128 | Pending flags, CPU-major, 16 per CPU |

## Verification
On every cycle the assertions check these properties: a reserved-mode generate leaves pending untouched, mode 1 never touches the writer's own bit, and mode 2 always makes the writer's bit pending. They also check that pending is frozen without a write, that offline CPUs stay unaffected by list and broadcast modes, and that reads outside the windows return zero. Only the bench's scenarios can show the source bitmaps themselves. That covers ORing from several writers, partial clears that keep an interrupt pending, a zero set that leaves it idle, lane placement for 8-bit and 32-bit window accesses, and bank separation between CPUs. The bench compares these through window reads and a per-clock comparison against its behavioural model.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_mode_e;

  typedef enum logic [1:0] {
    RGN_GEN,
    RGN_CLR,
    RGN_SET,
    RGN_NONE
  } rgn_e;

  // generate word field positions
  localparam int unsigned GEN_SGI_LSB  = 0;
  localparam int unsigned GEN_TGT_LSB  = 16;
  localparam int unsigned GEN_MODE_LSB = 24;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LANES       = 4;

endpackage

// File: rtl/sgi_target_sel.sv
module sgi_target_sel
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU = 8,
  localparam int unsigned CPU_W = $clog2(NCPU),
  localparam int unsigned CNT_W = $clog2(NCPU + 1)
) (
  input  logic [NCPU-1:0]  tgt_list_i,
  input  flt_mode_e        mode_i,
  input  logic [CPU_W-1:0] writer_i,
  input  logic [CNT_W-1:0] num_cpus_i,
  output logic [NCPU-1:0]  targets_o
);

  logic [NCPU-1:0] online;
  logic [NCPU-1:0] self_bit;

  always_comb begin
    online   = '0;
    self_bit = '0;
    for (int c = 0; c < NCPU; c++) begin
      online[c]   = (CNT_W'(c) < num_cpus_i);
      self_bit[c] = (CPU_W'(c) == writer_i);
    end
  end

  always_comb begin
    unique case (mode_i)
      FLT_LIST:   targets_o = tgt_list_i & online;
      FLT_OTHERS: targets_o = online & ~self_bit;
      FLT_SELF:   targets_o = self_bit;
      default:    targets_o = '0;
    endcase
  end

endmodule

// File: rtl/sgi_win_lanes.sv
module sgi_win_lanes
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU = 8,
  parameter int unsigned NSGI = 16,
  localparam int unsigned SGI_W = $clog2(NSGI)
) (
  input  logic [SGI_W-1:0]                  off_i,
  input  logic                              wide_i,
  input  logic [31:0]                       wdata_i,
  input  logic [NSGI-1:0][NCPU-1:0]         bank_i,
  output logic [NSGI-1:0]                   en_o,
  output logic [NSGI-1:0][NCPU-1:0]         data_o,
  output logic [31:0]                       rdata_o
);

  for (genvar s = 0; s < NSGI; s++) begin : g_lane
    localparam int unsigned LANE = s % LANES;
    localparam int unsigned WORD = s / LANES;
    assign en_o[s]   = wide_i ? (int'(off_i[SGI_W-1:2]) == WORD)
                              : (int'(off_i) == s);
    assign data_o[s] = wide_i ? wdata_i[BYTE_W*LANE +: NCPU]
                              : wdata_i[NCPU-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSGI; s++) begin
      if (en_o[s]) begin
        if (wide_i) rdata_o[BYTE_W*(s % LANES) +: NCPU] = bank_i[s];
        else        rdata_o[NCPU-1:0] = bank_i[s];
      end
    end
  end

endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU = 8,
  parameter int unsigned NSGI = 16,
  localparam int unsigned SGI_W = $clog2(NSGI)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      gen_hit_i,
  input  logic [SGI_W-1:0]          gen_sgi_i,
  input  logic [NCPU-1:0]           writer_bit_i,
  input  logic                      win_we_i,
  input  logic                      win_set_i,
  input  logic [NSGI-1:0]           win_en_i,
  input  logic [NSGI-1:0][NCPU-1:0] win_data_i,
  output logic [NSGI-1:0][NCPU-1:0] src_o,
  output logic [NSGI-1:0]           pend_o
);

  logic [NSGI-1:0][NCPU-1:0] src_q, src_d;

  always_comb begin
    src_d = src_q;
    for (int s = 0; s < NSGI; s++) begin
      if (gen_hit_i && gen_sgi_i == SGI_W'(s))
        src_d[s] = src_d[s] | writer_bit_i;
      if (win_we_i && win_en_i[s])
        src_d[s] = win_set_i ? (src_d[s] | win_data_i[s])
                             : (src_d[s] & ~win_data_i[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_d;
  end

  for (genvar s = 0; s < NSGI; s++) begin : g_pend
    assign pend_o[s] = |src_q[s];
  end

  assign src_o = src_q;

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU = 8,
  parameter int unsigned NSGI = 16,
  localparam int unsigned CPU_W  = $clog2(NCPU),
  localparam int unsigned CNT_W  = $clog2(NCPU + 1),
  localparam int unsigned SGI_W  = $clog2(NSGI),
  localparam int unsigned ADDR_W = SGI_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       num_cpus_i,
  input  logic [CPU_W-1:0]       cpu_id_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic                   wide_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NCPU*NSGI-1:0]   pending_o
);

  rgn_e rgn;
  always_comb begin
    unique case (addr_i[ADDR_W-1:SGI_W])
      2'd0:    rgn = (addr_i[SGI_W-1:2] == '0) ? RGN_GEN : RGN_NONE;
      2'd1:    rgn = RGN_CLR;
      2'd2:    rgn = RGN_SET;
      default: rgn = RGN_NONE;
    endcase
  end

  logic gen_wr, win_we, win_set, win_rgn;
  assign gen_wr  = req_i && we_i && wide_i && (rgn == RGN_GEN);
  assign win_rgn = (rgn == RGN_CLR) || (rgn == RGN_SET);
  assign win_we  = req_i && we_i && win_rgn;
  assign win_set = (rgn == RGN_SET);

  logic [NCPU-1:0] targets;
  logic [NCPU-1:0] writer_bit;
  logic [SGI_W-1:0] gen_sgi;

  assign gen_sgi = wdata_i[GEN_SGI_LSB +: SGI_W];

  always_comb begin
    writer_bit = '0;
    writer_bit[cpu_id_i] = 1'b1;
  end

  sgi_target_sel #(.NCPU(NCPU)) u_tsel (
    .tgt_list_i (wdata_i[GEN_TGT_LSB +: NCPU]),
    .mode_i     (flt_mode_e'(wdata_i[GEN_MODE_LSB +: 2])),
    .writer_i   (cpu_id_i),
    .num_cpus_i (num_cpus_i),
    .targets_o  (targets)
  );

  logic [NCPU-1:0][NSGI-1:0][NCPU-1:0] src_all;
  logic [NCPU-1:0][NSGI-1:0]           pend_all;
  logic [NSGI-1:0]                     lane_en;
  logic [NSGI-1:0][NCPU-1:0]           lane_data;
  logic [31:0]                         lane_rd;

  sgi_win_lanes #(.NCPU(NCPU), .NSGI(NSGI)) u_lanes (
    .off_i   (addr_i[SGI_W-1:0]),
    .wide_i  (wide_i),
    .wdata_i (wdata_i),
    .bank_i  (src_all[cpu_id_i]),
    .en_o    (lane_en),
    .data_o  (lane_data),
    .rdata_o (lane_rd)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    sgi_src_bank #(.NCPU(NCPU), .NSGI(NSGI)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .gen_hit_i    (gen_wr && targets[c]),
      .gen_sgi_i    (gen_sgi),
      .writer_bit_i (writer_bit),
      .win_we_i     (win_we && (cpu_id_i == CPU_W'(c))),
      .win_set_i    (win_set),
      .win_en_i     (lane_en),
      .win_data_i   (lane_data),
      .src_o        (src_all[c]),
      .pend_o       (pend_all[c])
    );
    assign pending_o[c*NSGI +: NSGI] = pend_all[c];
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= win_rgn ? lane_rd : 32'd0;
  end
  assign rdata_o = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[GEN_TGT_LSB-1:SGI_W], wdata_i[31:GEN_MODE_LSB+2]};

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int unsigned NCPU = 8,
  parameter int unsigned NSGI = 16,
  localparam int unsigned CPU_W  = $clog2(NCPU),
  localparam int unsigned CNT_W  = $clog2(NCPU + 1),
  localparam int unsigned SGI_W  = $clog2(NSGI),
  localparam int unsigned ADDR_W = SGI_W + 2,
  localparam int unsigned IDX_W  = $clog2(NCPU*NSGI)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CNT_W-1:0]     num_cpus_i,
  input logic [CPU_W-1:0]     cpu_id_i,
  input logic                 req_i,
  input logic                 we_i,
  input logic                 wide_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          wdata_i,
  input logic [31:0]          rdata_o,
  input logic [NCPU*NSGI-1:0] pending_o
);

  logic gen_wr;
  logic [1:0] mode;
  logic [IDX_W-1:0] self_idx;
  logic [NCPU*NSGI-1:0] off_mask;
  logic rd_outside;

  assign gen_wr   = req_i && we_i && wide_i && (addr_i[ADDR_W-1:2] == '0);
  assign mode     = wdata_i[25:24];
  assign self_idx = IDX_W'(cpu_id_i) * IDX_W'(NSGI) + IDX_W'(wdata_i[SGI_W-1:0]);
  assign rd_outside = req_i && !we_i &&
                      !(addr_i[ADDR_W-1:SGI_W] == 2'd1 || addr_i[ADDR_W-1:SGI_W] == 2'd2);

  always_comb begin
    off_mask = '0;
    for (int c = 0; c < NCPU; c++)
      for (int s = 0; s < NSGI; s++)
        off_mask[c*NSGI+s] = !(CNT_W'(c) < num_cpus_i);
  end

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd3 |=> $stable(pending_o)); // R5

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd1 |=> pending_o[$past(self_idx)] == $past(pending_o[self_idx])); // R3

  AST_SELF_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd2 |=> pending_o[$past(self_idx)]); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pending_o)); // R6

  AST_OFFLINE_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode != 2'd2 |=> (pending_o & off_mask) == ($past(pending_o) & off_mask)); // R7

  AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_outside |=> rdata_o == 32'd0); // R12

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .num_cpus_i (num_cpus_i),
  .cpu_id_i   (cpu_id_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .wide_i     (wide_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pending_o  (pending_o)
);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   num_cpus_i = 4'd4;
  logic [2:0]   cpu_id_i = '0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic         wide_i = 1'b0;
  logic [5:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] pending_o;

  sgi_dispatch uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural model: bitmap per (cpu, sgi), registered read value
  int src_m [8][16];
  int rd_m;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_pend();
    logic [127:0] v = '0;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++)
        v[c*16+s] = (src_m[c][s] != 0);
    return v;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++) src_m[c][s] = 0;
    rd_m = 0;
  endtask

  task automatic model_apply(input bit we, input bit wide, input int addr, input int data, input int cpu);
    int region = addr / 16;
    int nc = int'(num_cpus_i);
    if (we) begin
      if (region == 0 && (addr % 16) < 4 && wide) begin
        int sgi  = data % 16;
        int tl   = (data >> 16) & 8'hFF;
        int mode = (data >> 24) & 3;
        for (int c = 0; c < 8; c++) begin
          bit sel = 0;
          if (mode == 0) sel = (c < nc) && ((tl >> c) & 1);
          if (mode == 1) sel = (c < nc) && (c != cpu);
          if (mode == 2) sel = (c == cpu);
          if (sel) src_m[c][sgi] = src_m[c][sgi] | (1 << cpu);
        end
      end else if (region == 1 || region == 2) begin
        for (int l = 0; l < (wide ? 4 : 1); l++) begin
          int s = wide ? ((addr % 16) / 4) * 4 + l : addr % 16;
          int b = wide ? (data >> (8*l)) & 8'hFF : data & 8'hFF;
          if (region == 2) src_m[cpu][s] = src_m[cpu][s] | b;
          else             src_m[cpu][s] = src_m[cpu][s] & ~b & 8'hFF;
        end
      end
    end else begin
      rd_m = 0;
      if (region == 1 || region == 2)
        for (int l = 0; l < (wide ? 4 : 1); l++) begin
          int s = wide ? ((addr % 16) / 4) * 4 + l : addr % 16;
          rd_m = rd_m | (src_m[cpu][s] << (8*l));
        end
    end
  endtask

  task automatic bus(input bit we, input bit wide, input int addr, input int data, input int cpu);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; wide_i = wide;
    addr_i = 6'(addr); wdata_i = 32'(data); cpu_id_i = 3'(cpu);
    @(posedge clk_i);
    #1 model_apply(we, wide, addr, data, cpu);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  function automatic int gen_word(input int mode, input int tl, input int sgi);
    return (mode << 24) | (tl << 16) | sgi;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({cur_req, " R13 pending"}, pending_o, exp_pend());
      chk({cur_req, " R10 rdata"}, {96'd0, rdata_o}, {96'd0, 32'(rd_m)});
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    chk("R1 reset pending", pending_o, '0);
    chk("R1 reset rdata", {96'd0, rdata_o}, '0);
    rst_ni = 1'b1;

    cur_req = "R2";   // mode 0, list 0xF5 from cpu1, sgi3: cpus 0,2 only (R7)
    bus(1, 1, 6'h00, gen_word(0, 8'hF5, 3), 1);
    bus(0, 1, 6'h10, 0, 0);
    chk("R2 R7 list delivery cpu0", {96'd0, rdata_o}, {96'd0, 32'h0200_0000});
    bus(0, 0, 6'h13, 0, 2);
    chk("R2 list delivery cpu2", {96'd0, rdata_o}, {96'd0, 32'h0000_0002});

    cur_req = "R3";   // cpu2 broadcasts sgi5 to others
    bus(1, 1, 6'h00, gen_word(1, 8'h00, 5), 2);
    bus(0, 0, 6'h25, 0, 0);
    chk("R3 others cpu0 sgi5", {96'd0, rdata_o}, {96'd0, 32'h04});
    bus(0, 0, 6'h15, 0, 2);
    chk("R3 writer excluded", {96'd0, rdata_o}, {96'd0, 32'h00});

    cur_req = "R4";
    bus(1, 1, 6'h00, gen_word(2, 8'h01, 15), 3);
    bus(0, 1, 6'h2C, 0, 3);
    chk("R4 self delivery", {96'd0, rdata_o}, {96'd0, 32'h0800_0000});

    cur_req = "R5";
    bus(1, 1, 6'h00, gen_word(3, 8'hFF, 1), 0);
    bus(0, 0, 6'h11, 0, 1);
    chk("R5 reserved ignored", {96'd0, rdata_o}, {96'd0, 32'h00});

    cur_req = "R7";
    bus(1, 1, 6'h00, gen_word(0, 8'hF0, 9), 1);
    chk("R7 offline targets", pending_o, exp_pend());

    cur_req = "R6";   // two writers OR into cpu2 sgi5
    bus(1, 1, 6'h00, gen_word(0, 8'h04, 5), 0);
    bus(1, 1, 6'h00, gen_word(0, 8'h04, 5), 3);
    bus(0, 0, 6'h15, 0, 2);
    chk("R6 source OR", {96'd0, rdata_o}, {96'd0, 32'h09});

    cur_req = "R9";
    bus(1, 0, 6'h23, 32'h08, 0);
    bus(0, 0, 6'h13, 0, 0);
    chk("R9 set OR", {96'd0, rdata_o}, {96'd0, 32'h0A});
    bus(1, 0, 6'h27, 32'h00, 0);
    chk("R9 zero set stays idle", {127'd0, pending_o[7]}, 128'd0);

    cur_req = "R8";
    bus(1, 0, 6'h13, 32'h02, 0);
    chk("R8 partial clear keeps pending", {127'd0, pending_o[3]}, 128'd1);
    bus(1, 0, 6'h13, 32'h08, 0);
    chk("R8 full clear drops pending", {127'd0, pending_o[3]}, 128'd0);

    cur_req = "R11";
    bus(1, 1, 6'h24, 32'h0403_0201, 1);
    bus(0, 1, 6'h14, 0, 1);
    chk("R10 R11 wide set cpu1", {96'd0, rdata_o}, {96'd0, 32'h0403_0601});
    bus(0, 1, 6'h14, 0, 0);
    chk("R11 cpu0 bank untouched", {96'd0, rdata_o}, {96'd0, 32'h0000_0400});
    bus(1, 1, 6'h14, 32'hFFFF_FFFF, 1);
    chk("R8 wide clear", {124'd0, pending_o[16+4 +: 4]}, 128'd0);

    cur_req = "R12";
    bus(0, 1, 6'h00, 0, 0);
    chk("R12 gen read zero", {96'd0, rdata_o}, 128'd0);
    bus(1, 0, 6'h00, gen_word(2, 0, 2), 0);
    chk("R12 narrow gen ignored", {127'd0, pending_o[2]}, 128'd0);
    bus(1, 1, 6'h30, 32'hFFFF_FFFF, 0);
    bus(0, 1, 6'h30, 0, 0);
    chk("R12 unmapped read zero", {96'd0, rdata_o}, 128'd0);

    cur_req = "R1";
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_clear();
    @(negedge clk_i);
    chk("R1 mid-run reset", pending_o, '0);
    rst_ni = 1'b1;
    bus(0, 1, 6'h2C, 0, 3);
    chk("R1 bitmap cleared", {96'd0, rdata_o}, 128'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule